// File: doc/BRIEF.md
# Dual-Gate Charge Integrator for Pulse-Shape Discrimination

This block watches a stream of unsigned ADC samples, one per clock, and fires on its own when the signal rises through a programmable threshold. For each such pulse it sums the baseline-corrected samples over two windows that open together. The long window collects the whole pulse and gives its total charge, which is the energy. The short window covers only the leading edge. From the two sums the block forms the shape value (long − short)/long as an unsigned binary fraction. Scintillators that respond with different decay times for neutrons and for gammas can be told apart by this value.

A short delay line holds the samples, so both windows open a fixed number of samples before the threshold crossing and the rising edge is kept without any external signal delay. The baseline is the mean of a block of samples taken just before the windows open. It is frozen at the trigger and subtracted from every sample that is summed. A sequential restoring divider forms the fraction. When it finishes, the two sums, the fraction and a pile-up indication are presented together with a one-cycle strobe.

Top module: `psd_dual_gate`

## Requirements
- R1: After reset, `long_sum`, `short_sum`, `ratio` and `pileup` are 0 and `result_valid` is low.
- R2: A pulse starts when the block is idle and two consecutive input samples satisfy: the earlier one ≤ `thresh` and the later one > `thresh` (unsigned compare). That later sample is the crossing sample, index c.
- R3: Both gates open at input sample c−4. The long gate spans Le samples, where Le = `long_len`, or 1 when `long_len` is 0. The short gate spans min(Se, Le) samples, where Se = `short_len`, or 1 when `short_len` is 0.
- R4: The baseline is floor(sum of input samples c−20 … c−5 / 16). Each gated sample minus the baseline is added into a signed two's-complement sum 21 bits wide, which is reported as `long_sum` and `short_sum`.
- R5: With D = long − short, `ratio` is 0 when long ≤ 0 or D ≤ 0, is 1023 when D ≥ long, and is otherwise floor(D·1024/long).
- R6: `result_valid` is high for exactly one cycle, in the cycle after input sample c+Le+12 has been captured. The result outputs keep their values until the next strobe.
- R7: A rising crossing while a pulse is being integrated or divided starts no new pulse. `pileup` is 1 exactly when such a crossing has its crossing sample at an index in c+1 … c+Le.
- R8: Gate lengths are captured at the trigger. Changing `long_len` or `short_len` during a pulse does not affect that pulse's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_in | input | 12 | Unsigned ADC sample, one per cycle |
| thresh | input | 12 | Trigger level, unsigned |
| long_len | input | 8 | Long gate width in samples (0 acts as 1) |
| short_len | input | 8 | Short gate width in samples (0 acts as 1) |
| long_sum | output | 21 | Signed baseline-corrected long-gate charge (energy) |
| short_sum | output | 21 | Signed baseline-corrected short-gate charge |
| ratio | output | 10 | (long − short)/long as an unsigned fraction of 1024 |
| pileup | output | 1 | A second crossing occurred within the long gate |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench uses the default parameters: 12-bit samples, 8-bit gate widths, a 4-sample pre-trigger delay, a 16-sample baseline and a 10-bit fraction. With these, a 128-sample long gate (1.6 µs at 80 MHz) and a sample-sized short gate both fit, and each run stays short enough to also cover zero-length gates, a short gate longer than the long gate, negative and saturating ratios, and re-crossings in both the integration and the division phase. A baseline whose samples step through four values checks the floor in the averaging.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // How the final fraction is formed once the sums are known.
  typedef enum logic [1:0] {
    RM_DIVIDE = 2'd0,
    RM_ZERO   = 2'd1,
    RM_FULL   = 2'd2
  } ratio_mode_t;

  // A programmed gate width of zero is treated as one sample.
  function automatic int unsigned gate_eff(input int unsigned len);
    return (len == 0) ? 1 : len;
  endfunction

  function automatic int unsigned gate_min(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/psd_front.sv
// Sample delay line, running baseline sum and rising-edge trigger detection.
module psd_front #(
  parameter int SAMPLE_W = 12,
  parameter int PRE_DLY  = 4,
  parameter int BL_LOG2  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic [SAMPLE_W-1:0] thresh,
  output logic                crossing,
  output logic [SAMPLE_W-1:0] gate_sample,
  output logic [SAMPLE_W-1:0] baseline
);
  localparam int BL_N   = 1 << BL_LOG2;
  localparam int DEPTH  = PRE_DLY + BL_N + 1;
  localparam int BSUM_W = SAMPLE_W + BL_LOG2;

  logic [SAMPLE_W-1:0] tap [DEPTH];
  logic [BSUM_W-1:0]   bsum;

  // tap[0] is the newest sample; tap[PRE_DLY] enters the gates;
  // tap[PRE_DLY+1 .. DEPTH-1] form the baseline window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
      bsum <= '0;
    end else begin
      tap[0] <= sample_in;
      for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
      bsum <= bsum + BSUM_W'(tap[PRE_DLY]) - BSUM_W'(tap[DEPTH-1]);
    end
  end

  assign crossing    = (tap[0] > thresh) && (tap[1] <= thresh);
  assign gate_sample = tap[PRE_DLY];
  assign baseline    = SAMPLE_W'(bsum >> BL_LOG2);

endmodule

// File: rtl/psd_gate_acc.sv
// Two concurrent integration windows opened by one trigger.
module psd_gate_acc
  import psd_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int GATE_W   = 8,
  parameter int SUM_W    = 21
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       crossing,
  input  logic [SAMPLE_W-1:0]        sample,
  input  logic [SAMPLE_W-1:0]        baseline,
  input  logic [GATE_W-1:0]          long_len,
  input  logic [GATE_W-1:0]          short_len,
  output logic                       busy,
  output logic                       done,
  output logic                       pile,
  output logic [GATE_W-1:0]          cnt,
  output logic [GATE_W-1:0]          len_l,
  output logic signed [SUM_W-1:0]    acc_l,
  output logic signed [SUM_W-1:0]    acc_s
);
  logic [GATE_W-1:0]   len_s;
  logic [GATE_W-1:0]   l_eff;
  logic [GATE_W-1:0]   s_eff;
  logic [SAMPLE_W-1:0] base_q;
  logic                pile_q;
  logic signed [SUM_W-1:0] delta_first;
  logic signed [SUM_W-1:0] delta_run;

  // Sample minus baseline, sign-extended to the accumulator width.
  function automatic logic signed [SUM_W-1:0] excess(input logic [SAMPLE_W-1:0] s,
                                                     input logic [SAMPLE_W-1:0] b);
    logic signed [SAMPLE_W:0] d;
    d = $signed({1'b0, s}) - $signed({1'b0, b});
    return SUM_W'(d);
  endfunction

  always_comb begin
    l_eff = GATE_W'(gate_eff(32'(long_len)));
    s_eff = GATE_W'(gate_min(gate_eff(32'(short_len)), 32'(l_eff)));
  end

  assign delta_first = excess(sample, baseline);
  assign delta_run   = excess(sample, base_q);
  assign done        = busy && (cnt == len_l);
  assign pile        = pile_q | crossing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      len_l  <= '0;
      len_s  <= '0;
      base_q <= '0;
      acc_l  <= '0;
      acc_s  <= '0;
      pile_q <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= GATE_W'(1);
      len_l  <= l_eff;
      len_s  <= s_eff;
      base_q <= baseline;
      acc_l  <= delta_first;
      acc_s  <= delta_first;
      pile_q <= 1'b0;
    end else if (busy) begin
      if (done) begin
        busy <= 1'b0;
      end else begin
        acc_l <= acc_l + delta_run;
        if (cnt < len_s) acc_s <= acc_s + delta_run;
        cnt <= cnt + 1'b1;
      end
      if (crossing) pile_q <= 1'b1;
    end
  end

endmodule

// File: rtl/psd_ratio_div.sv
// Restoring divider that turns the two sums into (long - short)/long.
module psd_ratio_div
  import psd_pkg::*;
#(
  parameter int SUM_W  = 21,
  parameter int FRAC_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    pile_in,
  input  logic signed [SUM_W-1:0] long_in,
  input  logic signed [SUM_W-1:0] short_in,
  output logic                    busy,
  output logic                    valid,
  output logic                    pileup,
  output logic [FRAC_W-1:0]       ratio,
  output logic signed [SUM_W-1:0] long_sum,
  output logic signed [SUM_W-1:0] short_sum
);
  localparam int RW   = SUM_W + 2;
  localparam int IT_W = $clog2(FRAC_W + 1);

  logic [RW-1:0]           rem;
  logic [RW-1:0]           den;
  logic [FRAC_W-1:0]       quo;
  logic [IT_W-1:0]         it;
  ratio_mode_t             mode;
  ratio_mode_t             mode_now;
  logic signed [SUM_W-1:0] l_q;
  logic signed [SUM_W-1:0] s_q;
  logic                    p_q;
  logic signed [SUM_W:0]   diff;
  logic signed [SUM_W:0]   long_x;
  logic [RW:0]             step;

  // One quotient bit: shift the remainder and subtract the divisor if it fits.
  function automatic logic [RW:0] div_step(input logic [RW-1:0] r, input logic [RW-1:0] d);
    logic [RW-1:0] r2;
    r2 = r << 1;
    if (r2 >= d) return {1'b1, r2 - d};
    return {1'b0, r2};
  endfunction

  always_comb begin
    long_x = (SUM_W+1)'(long_in);
    diff   = long_x - (SUM_W+1)'(short_in);
    if (long_in <= 0 || diff <= 0) mode_now = RM_ZERO;
    else if (diff >= long_x)       mode_now = RM_FULL;
    else                           mode_now = RM_DIVIDE;
  end

  assign step = div_step(rem, den);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      valid     <= 1'b0;
      pileup    <= 1'b0;
      ratio     <= '0;
      long_sum  <= '0;
      short_sum <= '0;
      rem       <= '0;
      den       <= '0;
      quo       <= '0;
      it        <= '0;
      mode      <= RM_ZERO;
      l_q       <= '0;
      s_q       <= '0;
      p_q       <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        it   <= '0;
        mode <= mode_now;
        rem  <= RW'(diff);
        den  <= RW'(long_in);
        quo  <= '0;
        l_q  <= long_in;
        s_q  <= short_in;
        p_q  <= pile_in;
      end else if (busy) begin
        if (it != IT_W'(FRAC_W)) begin
          rem <= step[RW-1:0];
          quo <= {quo[FRAC_W-2:0], step[RW]};
          it  <= it + 1'b1;
        end else begin
          busy      <= 1'b0;
          valid     <= 1'b1;
          long_sum  <= l_q;
          short_sum <= s_q;
          pileup    <= p_q;
          case (mode)
            RM_ZERO: ratio <= '0;
            RM_FULL: ratio <= '1;
            default: ratio <= quo;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/psd_dual_gate.sv
// Self-triggered dual-gate charge integrator with on-chip shape ratio.
module psd_dual_gate
  import psd_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int GATE_W   = 8,
  parameter int PRE_DLY  = 4,
  parameter int BL_LOG2  = 4,
  parameter int FRAC_W   = 10,
  parameter int SUM_W    = SAMPLE_W + GATE_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SAMPLE_W-1:0]     sample_in,
  input  logic [SAMPLE_W-1:0]     thresh,
  input  logic [GATE_W-1:0]       long_len,
  input  logic [GATE_W-1:0]       short_len,
  output logic signed [SUM_W-1:0] long_sum,
  output logic signed [SUM_W-1:0] short_sum,
  output logic [FRAC_W-1:0]       ratio,
  output logic                    pileup,
  output logic                    result_valid
);
  // Named internal events, also watched by the bound checker.
  logic                    crossing;
  logic [SAMPLE_W-1:0]     gate_sample;
  logic [SAMPLE_W-1:0]     baseline;
  logic                    idle;
  logic                    start;
  logic                    gate_busy;
  logic                    gate_done;
  logic                    gate_pile;
  logic [GATE_W-1:0]       gate_cnt;
  logic [GATE_W-1:0]       gate_len;
  logic signed [SUM_W-1:0] acc_l;
  logic signed [SUM_W-1:0] acc_s;
  logic                    div_busy;

  assign idle  = !gate_busy && !div_busy;
  assign start = crossing && idle;

  psd_front #(
    .SAMPLE_W (SAMPLE_W),
    .PRE_DLY  (PRE_DLY),
    .BL_LOG2  (BL_LOG2)
  ) front_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_in   (sample_in),
    .thresh      (thresh),
    .crossing    (crossing),
    .gate_sample (gate_sample),
    .baseline    (baseline)
  );

  psd_gate_acc #(
    .SAMPLE_W (SAMPLE_W),
    .GATE_W   (GATE_W),
    .SUM_W    (SUM_W)
  ) gate_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .crossing  (crossing),
    .sample    (gate_sample),
    .baseline  (baseline),
    .long_len  (long_len),
    .short_len (short_len),
    .busy      (gate_busy),
    .done      (gate_done),
    .pile      (gate_pile),
    .cnt       (gate_cnt),
    .len_l     (gate_len),
    .acc_l     (acc_l),
    .acc_s     (acc_s)
  );

  psd_ratio_div #(
    .SUM_W  (SUM_W),
    .FRAC_W (FRAC_W)
  ) div_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (gate_done),
    .pile_in   (gate_pile),
    .long_in   (acc_l),
    .short_in  (acc_s),
    .busy      (div_busy),
    .valid     (result_valid),
    .pileup    (pileup),
    .ratio     (ratio),
    .long_sum  (long_sum),
    .short_sum (short_sum)
  );

endmodule

// File: rtl/psd_dual_gate_chk.sv
// Property checker attached to the top module.
module psd_dual_gate_chk #(
  parameter int GATE_W = 8,
  parameter int FRAC_W = 10,
  parameter int SUM_W  = 21
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    result_valid,
  input logic signed [SUM_W-1:0] long_sum,
  input logic [FRAC_W-1:0]       ratio,
  input logic                    gate_busy,
  input logic                    div_busy,
  input logic [GATE_W-1:0]       gate_cnt,
  input logic [GATE_W-1:0]       gate_len
);

  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  a_r6_strobe_after_divide: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(div_busy));

  a_r5_nonpositive_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && long_sum <= 0) |-> (ratio == '0));

  a_r7_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_busy && div_busy));

  a_r3_count_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
    gate_busy |-> (gate_cnt != '0 && gate_cnt <= gate_len));

endmodule

bind psd_dual_gate psd_dual_gate_chk #(
  .GATE_W (GATE_W),
  .FRAC_W (FRAC_W),
  .SUM_W  (SUM_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .result_valid (result_valid),
  .long_sum     (long_sum),
  .ratio        (ratio),
  .gate_busy    (gate_busy),
  .div_busy     (div_busy),
  .gate_cnt     (gate_cnt),
  .gate_len     (gate_len)
);

// File: tb/psd_dual_gate_tb_top.sv
`timescale 1ns/1ps
module psd_dual_gate_tb_top;

  typedef struct packed {
    logic [11:0] base;
    logic [11:0] peak;
    logic [3:0]  tau;
    logic [7:0]  lg;
    logic [7:0]  sg;
    logic [11:0] thr;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{12'd100,  12'd2000, 4'd3, 8'd20,  8'd4,  12'd600},
    '{12'd50,   12'd800,  4'd1, 8'd8,   8'd2,  12'd300},
    '{12'd3000, 12'd1000, 4'd6, 8'd128, 8'd10, 12'd3400},
    '{12'd200,  12'd100,  4'd2, 8'd6,   8'd6,  12'd250},
    '{12'd0,    12'd4000, 4'd4, 8'd5,   8'd9,  12'd1000},
    '{12'd10,   12'd500,  4'd2, 8'd0,   8'd0,  12'd100}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [11:0]        sample_in = '0;
  logic [11:0]        thresh = '0;
  logic [7:0]         long_len = '0;
  logic [7:0]         short_len = '0;
  logic signed [20:0] long_sum;
  logic signed [20:0] short_sum;
  logic [9:0]         ratio;
  logic               pileup;
  logic               result_valid;

  int checks = 0;
  int errors = 0;

  int hist [512];
  int n;
  int pat [64];
  int pat_len;
  int nvalid;
  int got_idx;
  longint got_long, got_short, got_ratio, got_pile;

  always #4 clk = ~clk;

  psd_dual_gate dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_in    (sample_in),
    .thresh       (thresh),
    .long_len     (long_len),
    .short_len    (short_len),
    .long_sum     (long_sum),
    .short_sum    (short_sum),
    .ratio        (ratio),
    .pileup       (pileup),
    .result_valid (result_valid)
  );

  task automatic expect_val(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one sample (called at a falling edge), then observe after the next rising edge.
  task automatic push(input int v);
    sample_in = 12'(v);
    hist[n] = v;
    n++;
    @(posedge clk);
    @(negedge clk);
    if (result_valid) begin
      if (nvalid == 0) begin
        got_idx   = n - 1;
        got_long  = long_sum;
        got_short = short_sum;
        got_ratio = ratio;
        got_pile  = pileup;
      end
      nvalid++;
    end
  endtask

  task automatic run_case(input string name, input int base, input int thr, input int lg,
                          input int sg, input bit wiggle, input bit change_len);
    int c, le, se, bs, v, rexp, pexp;
    longint el, es, d;
    thresh = 12'(thr);
    long_len = 8'(lg);
    short_len = 8'(sg);
    n = 0;
    nvalid = 0;
    got_idx = -1;
    for (int i = 0; i < 24; i++) push(base + (wiggle ? (i & 3) : 0));
    for (int i = 0; i < pat_len; i++) begin
      push(pat[i]);
      if (change_len && i == 2) begin
        long_len = 8'd60;
        short_len = 8'd40;
      end
    end
    for (int t = 0; t < 400 && nvalid == 0; t++) push(base);
    for (int t = 0; t < 30; t++) push(base);
    // Reference model built from the requirements.
    c = -1;
    for (int i = 1; i < n; i++)
      if (c < 0 && hist[i-1] <= thr && hist[i] > thr) c = i;
    le = (lg == 0) ? 1 : lg;
    se = (sg == 0) ? 1 : sg;
    if (se > le) se = le;
    bs = 0;
    for (int j = c - 20; j <= c - 5; j++) bs += hist[j];
    bs = bs / 16;
    el = 0;
    es = 0;
    for (int k = 0; k < le; k++) begin
      v = hist[c - 4 + k] - bs;
      el += v;
      if (k < se) es += v;
    end
    d = el - es;
    if (el <= 0 || d <= 0) rexp = 0;
    else if (d >= el)      rexp = 1023;
    else                   rexp = int'((d * 1024) / el);
    pexp = 0;
    for (int m = c + 1; m <= c + le; m++)
      if (hist[m-1] <= thr && hist[m] > thr) pexp = 1;
    $display("case %s: crossing %0d long %0d short %0d ratio %0d", name, c, el, es, rexp);
    expect_val({"R2/R6 strobe count ", name}, nvalid, 1);
    expect_val({"R6 strobe timing ", name}, got_idx, c + le + 12);
    expect_val({"R3/R4 long sum ", name}, got_long, el);
    expect_val({"R3/R4 short sum ", name}, got_short, es);
    expect_val({"R5 ratio ", name}, got_ratio, rexp);
    expect_val({"R7 pileup ", name}, got_pile, pexp);
    // R6: results held after the strobe
    expect_val({"R6 hold long ", name}, long_sum, el);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_val("R1 long_sum at reset", long_sum, 0);
    expect_val("R1 short_sum at reset", short_sum, 0);
    expect_val("R1 ratio at reset", ratio, 0);
    expect_val("R1 pileup at reset", pileup, 0);
    expect_val("R1 result_valid at reset", result_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table-driven pulses with a stepped baseline.
    for (int vi = 0; vi < NVEC; vi++) begin
      pat_len = 40;
      for (int k = 0; k < 40; k++) begin
        if (k == 0)      pat[k] = int'(VECS[vi].base) + int'(VECS[vi].peak) / 4;
        else if (k == 1) pat[k] = int'(VECS[vi].base) + int'(VECS[vi].peak);
        else pat[k] = int'(VECS[vi].base) + (int'(VECS[vi].peak) >> ((k - 1) / int'(VECS[vi].tau)));
      end
      run_case($sformatf("vec%0d", vi), int'(VECS[vi].base), int'(VECS[vi].thr),
               int'(VECS[vi].lg), int'(VECS[vi].sg), 1'b1, 1'b0);
    end

    // R5: negative long sum gives a zero ratio
    pat_len = 31;
    pat[0] = 2100;
    for (int k = 1; k < 31; k++) pat[k] = 0;
    run_case("negative", 2000, 2050, 10, 2, 1'b0, 1'b0);

    // R5: short sum negative, ratio saturates at 1023
    pat_len = 34;
    for (int k = 0; k < 4; k++) pat[k] = 0;
    for (int k = 4; k < 34; k++) pat[k] = 3000;
    run_case("saturate", 1000, 1100, 20, 4, 1'b0, 1'b0);

    // R7: re-crossing inside the long gate flags pile-up and starts nothing
    pat_len = 27;
    pat[0] = 1000; pat[1] = 1000; pat[2] = 100; pat[3] = 100; pat[4] = 100;
    pat[5] = 1000; pat[6] = 1000;
    for (int k = 7; k < 27; k++) pat[k] = 100;
    run_case("pileup", 100, 500, 20, 4, 1'b0, 1'b0);

    // R7: re-crossing during division is ignored and not flagged
    pat_len = 20;
    pat[0] = 1000;
    for (int k = 1; k < 20; k++) pat[k] = 100;
    pat[11] = 1000;
    run_case("div_window", 100, 500, 8, 3, 1'b0, 1'b0);

    // R8: gate widths changed after the trigger do not affect the pulse
    pat_len = 30;
    for (int k = 0; k < 30; k++) pat[k] = 1000 - 20 * k;
    run_case("len_change", 100, 500, 10, 3, 1'b0, 1'b1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule